// File: doc/BRIEF.md
# Remote Terminal Buffer Tag Tracker

This block holds a five-bit status tag for every subaddress data buffer of a remote terminal. Message handling logic reports events against one buffer at a time: a receive message starting to write the buffer, the same message finishing (with or without error, and marked if it was a broadcast), a host read of the buffer, and a transmit message sending the buffer out. The tag records whether the buffer holds good data, whether it changed since the host last read it, whether a write is in flight, whether the last good write came from a broadcast, and whether unread data has been overwritten.

The host or the message logic reads any tag through an indexed, combinational read port. When the flag option input is set, the block also raises a one-cycle subsystem flag request each time stale data goes out or unread data is overwritten. The request is meant to set the subsystem flag bit of the status word sent back on the bus. Buffer storage and command decoding live elsewhere.

Top module: `rt_data_tag_mgr`

## Requirements
- R1: After reset every tag reads 0 and the flag request output is low. Tag bit positions: bit 0 valid, bit 1 updated, bit 2 busy, bit 3 broadcast, bit 4 lost.
- R2: A receive start on a buffer sets its busy bit on the next clock edge and leaves valid, updated, broadcast and lost unchanged.
- R3: A receive completion without error clears busy and sets valid and updated. It also sets broadcast to the broadcast indication given with the completion.
- R4: A receive completion with error clears busy and valid and leaves updated, broadcast and lost unchanged.
- R5: A receive completion without error on a buffer whose updated bit is already set also sets its lost bit.
- R6: A host read clears the updated and lost bits of the buffer and leaves valid, busy and broadcast unchanged.
- R7: A transmit event leaves the tag of the buffer unchanged.
- R8: With the flag option set, a transmit of a buffer whose updated bit is clear pulses the flag request high for exactly the cycle after the event.
- R9: With the flag option set, an error-free receive completion on a buffer whose updated bit is already set pulses the flag request high for exactly the cycle after the event.
- R10: With the flag option clear, the flag request stays low whatever the events.
- R11: An event changes only the tag of the buffer selected by the event index. The read port shows the tag selected by the read index, independently of the event index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_idx_i | input | IDX_W (5) | Buffer addressed by the current event |
| rx_start_i | input | 1 | Receive message begins writing the buffer |
| rx_done_i | input | 1 | Receive message finished |
| rx_ok_i | input | 1 | Qualifies rx_done_i: 1 means no error |
| rx_bcast_i | input | 1 | Qualifies rx_done_i: message was broadcast |
| host_rd_i | input | 1 | Host has read the buffer |
| tx_send_i | input | 1 | Transmit message sends the buffer |
| sflag_en_i | input | 1 | Enables the subsystem flag request |
| rd_idx_i | input | IDX_W (5) | Buffer whose tag appears on tag_o |
| tag_o | output | 5 | Tag of buffer rd_idx_i |
| sflag_req_o | output | 1 | One-cycle subsystem flag request |

## Verification
The assertions assume the message logic and host present at most one event strobe per cycle, so no rule is needed for ordering two events that land on one edge. They also assume that rx_ok_i and rx_bcast_i carry meaning only while rx_done_i is high. The bench drives every event as a single isolated strobe held for one cycle, with the qualifiers set only alongside a completion. This keeps the stimulus inside those assumptions while it walks tags through overwrite, error and read sequences.

// File: rtl/rt_tag_pkg.sv
package rt_tag_pkg;
  typedef struct packed {
    logic lost;
    logic bcast;
    logic busy;
    logic upd;
    logic valid;
  } tag_t;

  typedef struct packed {
    logic rx_start;
    logic rx_done;
    logic rx_ok;
    logic rx_bcast;
    logic host_rd;
    logic tx_send;
  } tag_ev_t;

  localparam int unsigned TAG_W = $bits(tag_t);
endpackage

// File: rtl/rt_tag_cell.sv
module rt_tag_cell
  import rt_tag_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sel_i,
  input  tag_ev_t ev_i,
  output tag_t    tag_o
);
  tag_t tag_q, tag_d;

  always_comb begin
    tag_d = tag_q;
    if (sel_i) begin
      if (ev_i.rx_start) tag_d.busy = 1'b1;
      if (ev_i.rx_done) begin
        tag_d.busy = 1'b0;
        if (ev_i.rx_ok) begin
          tag_d.valid = 1'b1;
          tag_d.upd   = 1'b1;
          tag_d.bcast = ev_i.rx_bcast;
          if (tag_q.upd) tag_d.lost = 1'b1;
        end else begin
          tag_d.valid = 1'b0;
        end
      end
      if (ev_i.host_rd) begin
        tag_d.upd  = 1'b0;
        tag_d.lost = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tag_q <= '0;
    else         tag_q <= tag_d;
  end

  assign tag_o = tag_q;

  a_r2_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && ev_i.rx_start |=> tag_q.busy);
  a_r5_lost_on_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && ev_i.rx_done && ev_i.rx_ok && tag_q.upd |=> tag_q.lost);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && ev_i.host_rd |=> !tag_q.upd && !tag_q.lost);
  a_r11_unselected_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(tag_q));
  a_r3_lost_needs_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tag_q.lost) |-> $past(sel_i && ev_i.rx_done));
endmodule

// File: rtl/rt_tag_sflag.sv
module rt_tag_sflag
  import rt_tag_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  tag_ev_t ev_i,
  input  logic    sel_upd_i,
  output logic    req_o
);
  logic stale_tx, overwrite, req_q;

  assign stale_tx  = ev_i.tx_send && !sel_upd_i;
  assign overwrite = ev_i.rx_done && ev_i.rx_ok && sel_upd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= en_i && (stale_tx || overwrite);
  end

  assign req_o = req_q;

  a_r10_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o);
  a_r8_stale_tx_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ev_i.tx_send && !sel_upd_i |=> req_o);
  a_r9_flag_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.tx_send && !ev_i.rx_done |=> !req_o);
endmodule

// File: rtl/rt_data_tag_mgr.sv
module rt_data_tag_mgr
  import rt_tag_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] ev_idx_i,
  input  logic             rx_start_i,
  input  logic             rx_done_i,
  input  logic             rx_ok_i,
  input  logic             rx_bcast_i,
  input  logic             host_rd_i,
  input  logic             tx_send_i,
  input  logic             sflag_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             sflag_req_o
);
  tag_ev_t ev;
  tag_t    tags [NUM_BUF];
  logic [NUM_BUF-1:0] upd_vec;
  logic    sel_upd;

  assign ev = '{rx_start: rx_start_i, rx_done: rx_done_i, rx_ok: rx_ok_i,
                rx_bcast: rx_bcast_i, host_rd: host_rd_i, tx_send: tx_send_i};

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    rt_tag_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (ev_idx_i == IDX_W'(g)),
      .ev_i   (ev),
      .tag_o  (tags[g])
    );
    assign upd_vec[g] = tags[g].upd;
  end

  assign sel_upd = upd_vec[ev_idx_i];

  rt_tag_sflag i_sflag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (sflag_en_i),
    .ev_i      (ev),
    .sel_upd_i (sel_upd),
    .req_o     (sflag_req_o)
  );

  assign tag_o = tags[rd_idx_i];

  // input assumption: one event strobe per cycle
  a_r11_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_start_i, rx_done_i, host_rd_i, tx_send_i}));
endmodule

// File: tb/test_rt_data_tag_mgr.sv
module test_rt_data_tag_mgr;
  localparam int NB = 32;
  localparam int IW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0] ev_idx = '0, rd_idx = '0;
  logic rx_start = 0, rx_done = 0, rx_ok = 0, rx_bcast = 0, host_rd = 0, tx_send = 0, sflag_en = 0;
  logic [4:0] tag;
  logic sflag;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  rt_data_tag_mgr #(.NUM_BUF(NB)) i_rt_data_tag_mgr (
    .clk_i(clk), .rst_ni(rst_n), .ev_idx_i(ev_idx), .rx_start_i(rx_start),
    .rx_done_i(rx_done), .rx_ok_i(rx_ok), .rx_bcast_i(rx_bcast), .host_rd_i(host_rd),
    .tx_send_i(tx_send), .sflag_en_i(sflag_en), .rd_idx_i(rd_idx),
    .tag_o(tag), .sflag_req_o(sflag)
  );

  // tag bits: {lost,bcast,busy,upd,valid}
  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tag_at(int idx, string req, logic [4:0] exp);
    rd_idx = IW'(idx);
    #0.1;
    chk(req, tag, exp);
  endtask

  // kind: 0 start, 1 done ok, 2 done err, 3 read, 4 tx
  task automatic ev(int kind, int idx, logic bc = 1'b0);
    @(negedge clk);
    ev_idx = IW'(idx);
    case (kind)
      0: rx_start = 1;
      1: begin rx_done = 1; rx_ok = 1; rx_bcast = bc; end
      2: begin rx_done = 1; rx_ok = 0; rx_bcast = bc; end
      3: host_rd = 1;
      default: tx_send = 1;
    endcase
    @(negedge clk);
    {rx_start, rx_done, rx_ok, rx_bcast, host_rd, tx_send} = '0;
  endtask

  task automatic t_reset();
    tag_at(0, "R1", 5'b0);
    tag_at(31, "R1", 5'b0);
    chk("R1 sflag", {4'b0, sflag}, 5'b0);
  endtask

  task automatic t_rx_good();
    ev(0, 3);
    tag_at(3, "R2", 5'b00100);
    ev(1, 3, 1'b1);
    tag_at(3, "R3 bcast", 5'b01011);
    ev(3, 3);
    ev(1, 3, 1'b0);
    tag_at(3, "R3 non-bcast", 5'b00011);
  endtask

  task automatic t_lost_and_read();
    ev(1, 7);
    ev(0, 7);
    tag_at(7, "R2 keeps flags", 5'b00111);
    ev(1, 7, 1'b1);
    tag_at(7, "R5", 5'b11011);
    ev(3, 7);
    tag_at(7, "R6", 5'b01001);
  endtask

  task automatic t_rx_err();
    ev(1, 9);
    ev(1, 9, 1'b1);
    ev(0, 9);
    ev(2, 9);
    tag_at(9, "R4", 5'b11010);
  endtask

  task automatic t_tx();
    ev(1, 12);
    ev(4, 12);
    tag_at(12, "R7", 5'b00011);
  endtask

  task automatic t_sflag();
    sflag_en = 1;
    ev(3, 12);
    ev(4, 12);
    chk("R8 pulse", {4'b0, sflag}, 5'b1);
    @(negedge clk);
    chk("R8 single cycle", {4'b0, sflag}, 5'b0);
    ev(1, 12);
    ev(4, 12);
    chk("R8 fresh data no flag", {4'b0, sflag}, 5'b0);
    ev(1, 12);
    chk("R9 pulse", {4'b0, sflag}, 5'b1);
    @(negedge clk);
    chk("R9 single cycle", {4'b0, sflag}, 5'b0);
    sflag_en = 0;
    ev(1, 12);
    chk("R10 overwrite", {4'b0, sflag}, 5'b0);
    ev(3, 12);
    ev(4, 12);
    chk("R10 stale tx", {4'b0, sflag}, 5'b0);
  endtask

  task automatic t_isolation();
    ev_idx = 5'd20;
    ev(1, 20, 1'b1);
    tag_at(19, "R11 neighbour low", 5'b0);
    tag_at(21, "R11 neighbour high", 5'b0);
    tag_at(3, "R11 other buffer kept", 5'b00011);
    tag_at(20, "R11 target", 5'b01011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_rx_good();
    t_lost_and_read();
    t_rx_err();
    t_tx();
    t_sflag();
    t_isolation();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule